// File: doc/BRIEF.md
# Delayed Write Target Controller with Parity Error Handling

This block is the target-side control of a bus bridge for single-word delayed writes. Each write the initiator presents is sampled as an address, a command, one data word, the byte enables and a data parity bit. The block then does one of three things. It retries the write and stores it in a one-entry delayed write queue. It accepts the write and drops it when the data parity is bad and the initiator side has parity-error response enabled. Or it completes a queued write when the initiator tries the same write again after the far side has delivered it. The handshake outputs (target ready, stop and parity error) are all active low.

The queued entry is offered to the far-side master through a set of forward outputs. That master reports completion, together with whether the far-side target flagged a data parity error. A flagged error is held with the entry. When the matching re-attempt completes, the error is returned to the initiator as a delayed parity-error pulse. Two sticky status bits record parity events. Software clears them by writing ones through a small clear port.

Top module: `dwp_handler`

## Requirements
- R1: While reset is active, and until the first request after reset, trdy_n, stop_n and perr_n are high, fwd_valid is low and both status bits are low.
- R2: Data parity is even. A data parity error exists when the XOR of all 32 data bits, all 4 byte-enable bits and req_dpar is 1.
- R3: A request sampled with req_valid at a clock edge gets its response in the following cycle only. Retry means stop_n low with trdy_n high. Accept means trdy_n low, with stop_n also low when req_multi was set. Without a request, both stay high. With the queue empty and no enabled parity error, the response is retry, and from the next cycle fwd_valid is high with the captured address, command, data and byte enables on the fwd_* outputs.
- R4: With a data parity error and init_per_en high, the request is accepted (stop_n low as well if req_multi) and is not queued, whatever the queue state.
- R5: After that enabled-error accept, perr_n goes low for exactly one cycle, two cycles after the cycle in which trdy_n was low.
- R6: With a data parity error and init_per_en low, the request is handled like one with good parity: it is retried and queued when the queue is empty, and perr_n stays high.
- R7: stat_init_dpe is set by every request with a data parity error, whatever init_per_en is.
- R8: While the queue holds an entry, a request that does not complete it is retried and is not captured. While the entry waits for the far side, even a matching request is retried.
- R9: After far-side completion, a request matches when its address, command, data and byte enables equal the entry; the parity bit is not compared. A match is accepted and empties the queue (fwd_valid low from the next cycle).
- R10: far_done while the entry is waiting marks it delivered and lowers fwd_valid. far_perr at that edge is stored with the entry, and sets stat_far_dpd only when far_per_en is high. far_done at any other time has no effect.
- R11: When the completing match finds a stored far-side error, perr_n pulses low two cycles after the trdy_n cycle, whatever far_per_en is.
- R12: A csr_wr with csr_clr bit 0 set clears stat_init_dpe, and bit 1 clears stat_far_dpd. A set in the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| init_per_en | input | 1 | Initiator-side parity-error response enable |
| far_per_en | input | 1 | Far-side parity-error response enable |
| req_valid | input | 1 | Initiator write data phase present this cycle |
| req_multi | input | 1 | Initiator requests more than one data phase |
| req_addr | input | 32 | Write address |
| req_cmd | input | 4 | Write command |
| req_data | input | 32 | Write data |
| req_be | input | 4 | Byte enables |
| req_dpar | input | 1 | Even data parity bit |
| trdy_n | output | 1 | Target ready, active low |
| stop_n | output | 1 | Target stop, active low |
| perr_n | output | 1 | Data parity error to the initiator, active low |
| fwd_valid | output | 1 | Queued write waiting for far-side delivery |
| fwd_addr | output | 32 | Queued address |
| fwd_cmd | output | 4 | Queued command |
| fwd_data | output | 32 | Queued data |
| fwd_be | output | 4 | Queued byte enables |
| far_done | input | 1 | Far-side delivery of the queued write finished |
| far_perr | input | 1 | Far-side target flagged a data parity error on that delivery |
| csr_wr | input | 1 | Status clear write strobe |
| csr_clr | input | 2 | Write-one-to-clear mask: bit 0 initiator flag, bit 1 far-side flag |
| stat_init_dpe | output | 1 | Initiator-side detected parity error flag |
| stat_far_dpd | output | 1 | Far-side data parity detected flag |

## Verification
Inputs change on the falling edge, so the rising edge that samples a request is the next one. The bench checks trdy_n and stop_n at the falling edge right after that sampling edge, one register stage later. It checks perr_n at the next two falling edges: high at the first, low at the second. It checks it once more a cycle later to see the pulse has ended. Status bits and fwd_valid register at the sampling edge. The bench reads them only after the perr window, so each check lands in a cycle where its value is settled.

// File: rtl/dwp_pkg.sv
package dwp_pkg;

  typedef enum logic [1:0] {
    Q_EMPTY   = 2'd0,
    Q_PENDING = 2'd1,
    Q_DONE    = 2'd2
  } q_state_e;

  typedef enum logic [1:0] {
    RSP_IDLE   = 2'd0,
    RSP_RETRY  = 2'd1,
    RSP_ACCEPT = 2'd2,
    RSP_DISC   = 2'd3
  } rsp_e;

endpackage

// File: rtl/dwp_parity_chk.sv
module dwp_parity_chk #(
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic [DATA_W-1:0] data,
  input  logic [BE_W-1:0]   be,
  input  logic              par,
  output logic              err
);
  localparam int LANE_W = DATA_W / BE_W;

  logic [BE_W-1:0] lane_par;

  // one lane parity per byte enable, folded at the end
  for (genvar g = 0; g < BE_W; g++) begin : g_lane
    assign lane_par[g] = ^{data[g*LANE_W +: LANE_W], be[g]};
  end

  assign err = (^lane_par) ^ par;

endmodule

// File: rtl/dwp_entry_queue.sv
module dwp_entry_queue
  import dwp_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int CMD_W  = 4,
  parameter int DATA_W = 32,
  parameter int BE_W   = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              capture,
  input  logic              release_e,
  input  logic              far_done,
  input  logic              far_perr,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [CMD_W-1:0]  in_cmd,
  input  logic [DATA_W-1:0] in_data,
  input  logic [BE_W-1:0]   in_be,
  output q_state_e          state,
  output logic              match,
  output logic              far_err,
  output logic [ADDR_W-1:0] q_addr,
  output logic [CMD_W-1:0]  q_cmd,
  output logic [DATA_W-1:0] q_data,
  output logic [BE_W-1:0]   q_be
);

  q_state_e          state_q, state_d;
  logic              err_q, err_d, err_en;
  logic [ADDR_W-1:0] addr_q;
  logic [CMD_W-1:0]  cmd_q;
  logic [DATA_W-1:0] data_q;
  logic [BE_W-1:0]   be_q;
  logic              load_en;
  logic              deliver;

  assign load_en = capture && (state_q == Q_EMPTY);
  assign deliver = far_done && (state_q == Q_PENDING);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      Q_EMPTY:   if (capture)   state_d = Q_PENDING;
      Q_PENDING: if (far_done)  state_d = Q_DONE;
      Q_DONE:    if (release_e) state_d = Q_EMPTY;
      default:                  state_d = Q_EMPTY;
    endcase
  end

  always_comb begin
    err_en = load_en || deliver;
    err_d  = deliver ? far_perr : 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= Q_EMPTY;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      if (err_en) err_q <= err_d;
    end
  end

  // payload registers carry no reset; they are only read while occupied
  always_ff @(posedge clk) begin
    if (load_en) begin
      addr_q <= in_addr;
      cmd_q  <= in_cmd;
      data_q <= in_data;
      be_q   <= in_be;
    end
  end

  always_comb begin
    match = (state_q == Q_DONE) &&
            (in_addr == addr_q) && (in_cmd == cmd_q) &&
            (in_data == data_q) && (in_be == be_q);
  end

  assign state   = state_q;
  assign far_err = err_q;
  assign q_addr  = addr_q;
  assign q_cmd   = cmd_q;
  assign q_data  = data_q;
  assign q_be    = be_q;

endmodule

// File: rtl/dwp_responder.sv
module dwp_responder
  import dwp_pkg::*;
#(
  parameter int PERR_GAP = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  rsp_e rsp,
  input  logic perr_launch,
  output logic trdy_n,
  output logic stop_n,
  output logic perr_n
);

  logic              trdy_q, trdy_d;
  logic              stop_q, stop_d;
  logic [PERR_GAP:0] perr_sh_q, perr_sh_d;

  always_comb begin
    trdy_d = 1'b1;
    stop_d = 1'b1;
    unique case (rsp)
      RSP_RETRY:  stop_d = 1'b0;
      RSP_ACCEPT: trdy_d = 1'b0;
      RSP_DISC: begin
        trdy_d = 1'b0;
        stop_d = 1'b0;
      end
      default: ;
    endcase
  end

  generate
    if (PERR_GAP > 0) begin : g_gap
      assign perr_sh_d = {perr_sh_q[PERR_GAP-1:0], perr_launch};
    end else begin : g_nogap
      assign perr_sh_d = perr_launch;
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trdy_q    <= 1'b1;
      stop_q    <= 1'b1;
      perr_sh_q <= '0;
    end else begin
      trdy_q    <= trdy_d;
      stop_q    <= stop_d;
      perr_sh_q <= perr_sh_d;
    end
  end

  assign trdy_n = trdy_q;
  assign stop_n = stop_q;
  assign perr_n = ~perr_sh_q[PERR_GAP];

endmodule

// File: rtl/dwp_status.sv
module dwp_status #(
  parameter int N_BITS = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_BITS-1:0] set_v,
  input  logic              clr_wr,
  input  logic [N_BITS-1:0] clr_mask,
  output logic [N_BITS-1:0] flags
);

  logic [N_BITS-1:0] flags_q, flags_d;

  for (genvar g = 0; g < N_BITS; g++) begin : g_bit
    always_comb begin
      flags_d[g] = flags_q[g];
      if (clr_wr && clr_mask[g]) flags_d[g] = 1'b0;
      if (set_v[g])              flags_d[g] = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end

  assign flags = flags_q;

endmodule

// File: rtl/dwp_handler.sv
module dwp_handler
  import dwp_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CMD_W    = 4,
  parameter int DATA_W   = 32,
  parameter int PERR_GAP = 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 init_per_en,
  input  logic                 far_per_en,
  input  logic                 req_valid,
  input  logic                 req_multi,
  input  logic [ADDR_W-1:0]    req_addr,
  input  logic [CMD_W-1:0]     req_cmd,
  input  logic [DATA_W-1:0]    req_data,
  input  logic [DATA_W/8-1:0]  req_be,
  input  logic                 req_dpar,
  output logic                 trdy_n,
  output logic                 stop_n,
  output logic                 perr_n,
  output logic                 fwd_valid,
  output logic [ADDR_W-1:0]    fwd_addr,
  output logic [CMD_W-1:0]     fwd_cmd,
  output logic [DATA_W-1:0]    fwd_data,
  output logic [DATA_W/8-1:0]  fwd_be,
  input  logic                 far_done,
  input  logic                 far_perr,
  input  logic                 csr_wr,
  input  logic [1:0]           csr_clr,
  output logic                 stat_init_dpe,
  output logic                 stat_far_dpd
);

  localparam int BE_W = DATA_W / 8;
  localparam int ST_INIT = 0;
  localparam int ST_FAR  = 1;

  // asynchronous assert, synchronous release
  logic [1:0] rst_sync_q;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_sync_n = rst_sync_q[1];

  logic     data_perr;
  logic     enabled_err;
  q_state_e q_state;
  logic     q_match;
  logic     q_far_err;
  logic     capture;
  logic     release_e;
  logic     perr_launch;
  rsp_e     rsp;
  logic [1:0] stat_set;
  logic [1:0] stat_flags;

  dwp_parity_chk #(
    .DATA_W (DATA_W),
    .BE_W   (BE_W)
  ) i_par (
    .data (req_data),
    .be   (req_be),
    .par  (req_dpar),
    .err  (data_perr)
  );

  assign enabled_err = req_valid && data_perr && init_per_en;

  // response selection for the sampled request
  always_comb begin
    rsp         = RSP_IDLE;
    capture     = 1'b0;
    release_e   = 1'b0;
    perr_launch = 1'b0;
    if (req_valid) begin
      if (enabled_err) begin
        rsp         = req_multi ? RSP_DISC : RSP_ACCEPT;
        perr_launch = 1'b1;
      end else begin
        unique case (q_state)
          Q_EMPTY: begin
            rsp     = RSP_RETRY;
            capture = 1'b1;
          end
          Q_DONE: begin
            if (q_match) begin
              rsp         = req_multi ? RSP_DISC : RSP_ACCEPT;
              release_e   = 1'b1;
              perr_launch = q_far_err;
            end else begin
              rsp = RSP_RETRY;
            end
          end
          default: rsp = RSP_RETRY;
        endcase
      end
    end
  end

  dwp_entry_queue #(
    .ADDR_W (ADDR_W),
    .CMD_W  (CMD_W),
    .DATA_W (DATA_W),
    .BE_W   (BE_W)
  ) i_queue (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .capture   (capture),
    .release_e (release_e),
    .far_done  (far_done),
    .far_perr  (far_perr),
    .in_addr   (req_addr),
    .in_cmd    (req_cmd),
    .in_data   (req_data),
    .in_be     (req_be),
    .state     (q_state),
    .match     (q_match),
    .far_err   (q_far_err),
    .q_addr    (fwd_addr),
    .q_cmd     (fwd_cmd),
    .q_data    (fwd_data),
    .q_be      (fwd_be)
  );

  assign fwd_valid = (q_state == Q_PENDING);

  dwp_responder #(
    .PERR_GAP (PERR_GAP)
  ) i_rsp (
    .clk         (clk),
    .rst_n       (rst_sync_n),
    .rsp         (rsp),
    .perr_launch (perr_launch),
    .trdy_n      (trdy_n),
    .stop_n      (stop_n),
    .perr_n      (perr_n)
  );

  always_comb begin
    stat_set          = '0;
    stat_set[ST_INIT] = req_valid && data_perr;
    stat_set[ST_FAR]  = far_done && (q_state == Q_PENDING) && far_perr && far_per_en;
  end

  dwp_status #(
    .N_BITS (2)
  ) i_stat (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .set_v    (stat_set),
    .clr_wr   (csr_wr),
    .clr_mask (csr_clr),
    .flags    (stat_flags)
  );

  assign stat_init_dpe = stat_flags[ST_INIT];
  assign stat_far_dpd  = stat_flags[ST_FAR];

endmodule

// File: rtl/dwp_handler_chk.sv
module dwp_handler_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       req_multi,
  input logic       init_per_en,
  input logic       far_done,
  input logic       far_perr,
  input logic       far_per_en,
  input logic       csr_wr,
  input logic [1:0] csr_clr,
  input logic       data_perr,
  input logic       trdy_n,
  input logic       stop_n,
  input logic       perr_n,
  input logic       fwd_valid,
  input logic       stat_init_dpe,
  input logic       stat_far_dpd
);

  a_r3_resp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> (!trdy_n || !stop_n));

  a_r3_idle_without_req: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (trdy_n && stop_n));

  a_r4_enabled_err_accept: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && data_perr && init_per_en) |=> (!trdy_n && (stop_n == !$past(req_multi))));

  a_r5_perr_after_trdy: assert property (@(posedge clk) disable iff (!rst_n)
    !perr_n |-> $past(!trdy_n, 2));

  a_r7_dpe_set: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && data_perr) |=> stat_init_dpe);

  a_r8_pending_retry: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && fwd_valid && !(data_perr && init_per_en)) |=> (trdy_n && !stop_n));

  a_r10_dpd_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(stat_far_dpd) |-> $past(far_done && far_perr && far_per_en));

  a_r12_clear_dpe: assert property (@(posedge clk) disable iff (!rst_n)
    (csr_wr && csr_clr[0] && !(req_valid && data_perr)) |=> !stat_init_dpe);

endmodule

bind dwp_handler dwp_handler_chk i_chk (
  .clk           (clk),
  .rst_n         (rst_sync_n),
  .req_valid     (req_valid),
  .req_multi     (req_multi),
  .init_per_en   (init_per_en),
  .far_done      (far_done),
  .far_perr      (far_perr),
  .far_per_en    (far_per_en),
  .csr_wr        (csr_wr),
  .csr_clr       (csr_clr),
  .data_perr     (data_perr),
  .trdy_n        (trdy_n),
  .stop_n        (stop_n),
  .perr_n        (perr_n),
  .fwd_valid     (fwd_valid),
  .stat_init_dpe (stat_init_dpe),
  .stat_far_dpd  (stat_far_dpd)
);

// File: tb/test_dwp_handler.sv
module test_dwp_handler;

  logic        clk;
  logic        rst_n;
  logic        init_per_en, far_per_en;
  logic        req_valid, req_multi;
  logic [31:0] req_addr;
  logic [3:0]  req_cmd;
  logic [31:0] req_data;
  logic [3:0]  req_be;
  logic        req_dpar;
  logic        trdy_n, stop_n, perr_n;
  logic        fwd_valid;
  logic [31:0] fwd_addr;
  logic [3:0]  fwd_cmd;
  logic [31:0] fwd_data;
  logic [3:0]  fwd_be;
  logic        far_done, far_perr;
  logic        csr_wr;
  logic [1:0]  csr_clr;
  logic        stat_init_dpe, stat_far_dpd;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  dwp_handler i_dwp_handler (
    .clk(clk), .rst_n(rst_n), .init_per_en(init_per_en), .far_per_en(far_per_en),
    .req_valid(req_valid), .req_multi(req_multi), .req_addr(req_addr),
    .req_cmd(req_cmd), .req_data(req_data), .req_be(req_be), .req_dpar(req_dpar),
    .trdy_n(trdy_n), .stop_n(stop_n), .perr_n(perr_n), .fwd_valid(fwd_valid),
    .fwd_addr(fwd_addr), .fwd_cmd(fwd_cmd), .fwd_data(fwd_data), .fwd_be(fwd_be),
    .far_done(far_done), .far_perr(far_perr), .csr_wr(csr_wr), .csr_clr(csr_clr),
    .stat_init_dpe(stat_init_dpe), .stat_far_dpd(stat_far_dpd)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;  // 50 MHz

  // kind: 0 request, 1 far-side completion, 2 status clear
  typedef struct packed {
    logic [1:0]  kind;
    logic [31:0] addr;
    logic [3:0]  cmd;
    logic [31:0] data;
    logic [3:0]  be;
    logic        multi;
    logic        badpar;
    logic        iperen;
    logic        fperen;
    logic        fperr;
    logic [1:0]  clr;
    logic        e_trdy;
    logic        e_stop;
    logic        e_perr;
    logic        e_dpe;
    logic        e_dpd;
    logic        e_fwd;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 18;
  localparam logic [31:0] AA = 32'h0000_0100, DA = 32'h1111_1111;
  localparam logic [31:0] AB = 32'h0000_0104, DB = 32'h2222_2222;
  localparam logic [31:0] AC = 32'h0000_0200, DC = 32'h3333_3333;
  localparam logic [31:0] AD = 32'h0000_0300, DD = 32'h4444_4444;

  localparam vec_t VEC [NV] = '{
    '{2'd0, AA, 4'h7, DA, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3},  // R3 capture
    '{2'd0, AA, 4'h7, DA, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 match while pending
    '{2'd0, AB, 4'h7, DB, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd8},  // R8 other while pending
    '{2'd1, AA, 4'h7, DA, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 clean delivery
    '{2'd0, AB, 4'h7, DB, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd8},  // R8 not captured
    '{2'd0, AA, 4'h7, DA, 4'h3, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 be differs
    '{2'd0, AA, 4'h7, DA, 4'hF, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 4'd9},  // R9 match, disconnect
    '{2'd0, AC, 4'h7, DC, 4'hF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 4'd5},  // R2 R4 R5 R7
    '{2'd0, AC, 4'h7, DC, 4'hF, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 4'd4},  // R4 multi
    '{2'd2, AA, 4'h7, DA, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b01, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd12}, // R12 clear bit 0
    '{2'd0, AC, 4'h7, DC, 4'hF, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 4'd6},  // R6 R7 disabled
    '{2'd1, AC, 4'h7, DC, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 4'd10}, // R10 far error enabled
    '{2'd0, AC, 4'h7, DC, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 4'd11}, // R11 R9 parity ignored
    '{2'd2, AA, 4'h7, DA, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b11, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd12}, // R12 clear both
    '{2'd0, AD, 4'h7, DD, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 4'd3},  // R3
    '{2'd1, AD, 4'h7, DD, 4'hF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd10}, // R10 far error, disabled
    '{2'd0, AD, 4'h7, DD, 4'hF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 4'd11}, // R11 forwarded anyway
    '{2'd1, AD, 4'h7, DD, 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 2'b00, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 4'd10}  // R10 ignored when empty
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle_inputs();
    req_valid = 1'b0;
    req_multi = 1'b0;
    far_done  = 1'b0;
    far_perr  = 1'b0;
    csr_wr    = 1'b0;
    csr_clr   = 2'b00;
  endtask

  task automatic drive_req(input logic [31:0] a, input logic [3:0] c, input logic [31:0] d,
                           input logic [3:0] b, input logic m, input logic bad);
    req_valid = 1'b1;
    req_addr  = a;
    req_cmd   = c;
    req_data  = d;
    req_be    = b;
    req_multi = m;
    req_dpar  = (^{d, b}) ^ bad;  // R2 even parity
  endtask

  task automatic run_vec(input vec_t v, input int idx);
    string tag;
    tag = $sformatf("R%0d vec%0d", v.rq, idx);
    @(negedge clk);
    init_per_en = v.iperen;
    far_per_en  = v.fperen;
    far_perr    = v.fperr;
    case (v.kind)
      2'd0: drive_req(v.addr, v.cmd, v.data, v.be, v.multi, v.badpar);
      2'd1: far_done = 1'b1;
      default: begin
        csr_wr  = 1'b1;
        csr_clr = v.clr;
      end
    endcase
    @(negedge clk);
    idle_inputs();
    check({tag, " trdy_n"}, 32'(trdy_n), 32'(v.e_trdy));
    check({tag, " stop_n"}, 32'(stop_n), 32'(v.e_stop));
    @(negedge clk);
    check({tag, " perr_n early"}, 32'(perr_n), 32'd1);
    @(negedge clk);
    check({tag, " perr_n"}, 32'(perr_n), 32'(v.e_perr));
    @(negedge clk);
    check({tag, " perr_n end"}, 32'(perr_n), 32'd1);
    check({tag, " stat_init_dpe"}, 32'(stat_init_dpe), 32'(v.e_dpe));
    check({tag, " stat_far_dpd"}, 32'(stat_far_dpd), 32'(v.e_dpd));
    check({tag, " fwd_valid"}, 32'(fwd_valid), 32'(v.e_fwd));
  endtask

  task automatic finish_run();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired actual=running expected=done");
      finish_run();
    end
  end

  initial begin
    rst_n       = 1'b0;
    init_per_en = 1'b1;
    far_per_en  = 1'b1;
    req_addr    = '0;
    req_cmd     = '0;
    req_data    = '0;
    req_be      = '0;
    req_dpar    = 1'b0;
    idle_inputs();
    repeat (3) @(negedge clk);
    // R1 during reset
    check("R1 trdy_n in reset", 32'(trdy_n), 32'd1);
    check("R1 stop_n in reset", 32'(stop_n), 32'd1);
    check("R1 perr_n in reset", 32'(perr_n), 32'd1);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 after release
    check("R1 fwd_valid", 32'(fwd_valid), 32'd0);
    check("R1 stat_init_dpe", 32'(stat_init_dpe), 32'd0);
    check("R1 stat_far_dpd", 32'(stat_far_dpd), 32'd0);
    check("R1 stop_n idle", 32'(stop_n), 32'd1);

    for (int i = 0; i < NV; i++) run_vec(VEC[i], i);

    // R3 captured fields appear on the forward outputs
    @(negedge clk);
    init_per_en = 1'b1;
    drive_req(32'hA5A5_0040, 4'hF, 32'hDEAD_BEEF, 4'h6, 1'b0, 1'b0);
    @(negedge clk);
    idle_inputs();
    check("R3 fwd_valid", 32'(fwd_valid), 32'd1);
    check("R3 fwd_addr", fwd_addr, 32'hA5A5_0040);
    check("R3 fwd_cmd", 32'(fwd_cmd), 32'hF);
    check("R3 fwd_data", fwd_data, 32'hDEAD_BEEF);
    check("R3 fwd_be", 32'(fwd_be), 32'h6);

    // R1 reset empties a pending entry
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    check("R1 fwd_valid after reset", 32'(fwd_valid), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R12 set wins over a clear in the same cycle
    init_per_en = 1'b1;
    drive_req(32'h0000_0500, 4'h7, 32'h0F0F_0F0F, 4'hF, 1'b0, 1'b1);
    csr_wr  = 1'b1;
    csr_clr = 2'b01;
    @(negedge clk);
    idle_inputs();
    check("R12 set beats clear", 32'(stat_init_dpe), 32'd1);
    csr_wr  = 1'b1;
    csr_clr = 2'b10;
    @(negedge clk);
    idle_inputs();
    check("R12 other bit leaves dpe", 32'(stat_init_dpe), 32'd1);
    csr_wr  = 1'b1;
    csr_clr = 2'b01;
    @(negedge clk);
    idle_inputs();
    check("R12 clear alone", 32'(stat_init_dpe), 32'd0);
    repeat (3) @(negedge clk);

    done = 1'b1;
    finish_run();
  end

endmodule